// File: doc/BRIEF.md
# Double-Buffered Frame Transfer Sequencer

This block sits between two video FIFOs and a memory-mapped DMA engine. It issues the DMA commands that let two frame regions in DRAM act as a ping-pong pair. A camera fills the regions at 30 frames per second, and a display drains them at 60. The block never touches pixel data. It watches one level flag per FIFO and produces command words, each holding a start address, a byte count and a tag. It then waits for the matching completion status.

The block has two halves that run independently. The fill half writes 64-byte bursts (eight 64-bit beats) into its current region. It switches to the other region as soon as it finishes one. The drain half reads bursts back into the display FIFO. At the end of a region it moves on only if the other region has been completely filled; otherwise it reads the same region again, so no torn frame is shown. The only state the halves share is which region holds a finished frame.

The address step between bursts is a multiple of the burst size, so the block can work around an engine that leaves gaps. An optional read-side offset corrects an engine that shifts the written stream by a fixed number of bytes. With the offset enabled, the first read of a region skips that many bytes, and the missing tail is fetched from the start of the other region. At the defaults, a frame of 640×480 pixels in 16-bit slots is 9600 bursts.

Top module: `fbdma_top`

## Requirements
- R1: Every fill command has a byte count of XFER_BYTES (64). Fill burst k of a region starts at the region base plus k·XFER_BYTES·STRIDE_MUL.
- R2: The fill half raises a command only after sampling `inHasBurst` high while it is idle. While `inHasBurst` is low it issues nothing.
- R3: The drain half raises a command only after sampling `outHasRoom` high while it is idle. While `outHasRoom` is low it issues nothing.
- R4: Each half has at most one command outstanding. A status is accepted only when its tag equals the tag of that half's outstanding command. A status with any other tag is ignored, and the half keeps waiting.
- R5: After the fill half completes burst FRAME_XFERS-1 of a region, its next command targets burst 0 of the other region.
- R6: At the end of a region, the drain half switches to the other region only if the fill half has completed that region and has not since started rewriting it. Otherwise the drain half rereads its current region from burst 0.
- R7: After reset, both halves point at region 0 (base BASE0). The drain half issues nothing until the first full region has been written.
- R8: With SKEW_BYTES>0, a region read is FRAME_XFERS+1 commands. The first starts at base+SKEW_BYTES with count XFER_BYTES-SKEW_BYTES. Middle burst k (1..FRAME_XFERS-1) starts at base+k·XFER_BYTES·STRIDE_MUL with count XFER_BYTES. The last starts at the other region's base with count SKEW_BYTES.
- R9: A status accepted with its error bit set raises `errFlag`, which stays high until reset.
- R10: During and right after reset, neither command valid is high and `errFlag` is low.
- R11: Each half tags its first command after reset 0. Each later command carries the previous tag plus one, modulo 2^TAG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inHasBurst | input | 1 | Input FIFO holds at least one full burst |
| outHasRoom | input | 1 | Display FIFO has room for one full burst |
| wrCmdValid | output | 1 | Fill command valid |
| wrCmdReady | input | 1 | Engine accepts fill command |
| wrCmdAddr | output | ADDR_W | Fill command start address |
| wrCmdLen | output | LEN_W | Fill command byte count |
| wrCmdTag | output | TAG_W | Fill command tag |
| wrStsValid | input | 1 | Fill status valid |
| wrStsTag | input | TAG_W | Fill status tag |
| wrStsErr | input | 1 | Fill status error |
| rdCmdValid | output | 1 | Drain command valid |
| rdCmdReady | input | 1 | Engine accepts drain command |
| rdCmdAddr | output | ADDR_W | Drain command start address |
| rdCmdLen | output | LEN_W | Drain command byte count |
| rdCmdTag | output | TAG_W | Drain command tag |
| rdStsValid | input | 1 | Drain status valid |
| rdStsTag | input | TAG_W | Drain status tag |
| rdStsErr | input | 1 | Drain status error |
| errFlag | output | 1 | Sticky error indication |

## Verification
The bench builds the block with FRAME_XFERS=3, STRIDE_MUL=2, SKEW_BYTES=32, TAG_W=4 and small region bases. At these values a region wrap, the skewed first read, and the tail read from the other region all occur within a few commands. The short frame also lets the drain half reach its end-of-region decision both before and after the fill half finishes. That covers the reread and the swap, including a reread caused by the writer returning to a region. The drain tag passes 15 and wraps to 0 within the run.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
  // per-half strobes from control to datapath
  typedef struct packed {
    logic step;      // advance to next burst of the region
    logic wrapSame;  // restart current region
    logic wrapSwap;  // restart in the other region
  } stepCtl_t;

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_t;
endpackage

// File: rtl/fbdma_ctrl.sv
module fbdma_ctrl
  import fbdma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inHasBurst,
  input  logic     outHasRoom,
  input  logic     wrCmdReady,
  input  logic     rdCmdReady,
  input  logic     wrTagHit,
  input  logic     rdTagHit,
  input  logic     wrLast,
  input  logic     rdLast,
  input  logic     wrBuf,
  input  logic     rdBuf,
  output logic     wrCmdValid,
  output logic     rdCmdValid,
  output stepCtl_t wrCtl,
  output stepCtl_t rdCtl
);
  phase_t     wrPh, rdPh;
  logic [1:0] regionFull;  // region holds a complete, untouched frame
  logic       frameSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPh       <= PH_IDLE;
      rdPh       <= PH_IDLE;
      regionFull <= '0;
      frameSeen  <= 1'b0;
    end else begin
      unique case (wrPh)
        PH_IDLE:  if (inHasBurst) wrPh <= PH_ISSUE;
        PH_ISSUE: if (wrCmdReady) wrPh <= PH_WAIT;
        PH_WAIT:  if (wrTagHit)   wrPh <= PH_IDLE;
        default:  wrPh <= PH_IDLE;
      endcase
      unique case (rdPh)
        PH_IDLE:  if (outHasRoom && frameSeen) rdPh <= PH_ISSUE;
        PH_ISSUE: if (rdCmdReady) rdPh <= PH_WAIT;
        PH_WAIT:  if (rdTagHit)   rdPh <= PH_IDLE;
        default:  rdPh <= PH_IDLE;
      endcase
      if (wrCtl.wrapSwap) begin
        regionFull[wrBuf]  <= 1'b1;
        regionFull[~wrBuf] <= 1'b0;  // writer now overwrites it
        frameSeen          <= 1'b1;
      end
    end
  end

  always_comb begin
    wrCmdValid     = (wrPh == PH_ISSUE);
    rdCmdValid     = (rdPh == PH_ISSUE);
    wrCtl          = '0;
    rdCtl          = '0;
    wrCtl.step     = (wrPh == PH_WAIT) && wrTagHit && !wrLast;
    wrCtl.wrapSwap = (wrPh == PH_WAIT) && wrTagHit && wrLast;
    rdCtl.step     = (rdPh == PH_WAIT) && rdTagHit && !rdLast;
    rdCtl.wrapSwap = (rdPh == PH_WAIT) && rdTagHit && rdLast && regionFull[~rdBuf];
    rdCtl.wrapSame = (rdPh == PH_WAIT) && rdTagHit && rdLast && !regionFull[~rdBuf];
  end
endmodule

// File: rtl/fbdma_path.sv
module fbdma_path
  import fbdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 4,
  parameter int XFER_BYTES  = 64,
  parameter int STRIDE_MUL  = 2,
  parameter int SKEW_BYTES  = 32,
  parameter int FRAME_XFERS = 9600,
  parameter logic [ADDR_W-1:0] BASE0 = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] BASE1 = 32'h8020_0000,
  localparam int LEN_W = $clog2(XFER_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          wrCtl,
  input  stepCtl_t          rdCtl,
  input  logic              wrStsValid,
  input  logic [TAG_W-1:0]  wrStsTag,
  input  logic              wrStsErr,
  input  logic              rdStsValid,
  input  logic [TAG_W-1:0]  rdStsTag,
  input  logic              rdStsErr,
  output logic [ADDR_W-1:0] wrCmdAddr,
  output logic [LEN_W-1:0]  wrCmdLen,
  output logic [TAG_W-1:0]  wrCmdTag,
  output logic [ADDR_W-1:0] rdCmdAddr,
  output logic [LEN_W-1:0]  rdCmdLen,
  output logic [TAG_W-1:0]  rdCmdTag,
  output logic              wrTagHit,
  output logic              rdTagHit,
  output logic              wrLast,
  output logic              rdLast,
  output logic              wrBuf,
  output logic              rdBuf,
  output logic              errFlag
);
  localparam int RD_LAST = (SKEW_BYTES > 0) ? FRAME_XFERS : FRAME_XFERS - 1;
  localparam int IDX_W   = $clog2(RD_LAST + 2);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(XFER_BYTES * STRIDE_MUL);

  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic [ADDR_W-1:0] wrBase, rdBase, rdOther;
  logic              wrDone, rdDone;

  assign wrDone  = wrCtl.step | wrCtl.wrapSame | wrCtl.wrapSwap;
  assign rdDone  = rdCtl.step | rdCtl.wrapSame | rdCtl.wrapSwap;
  assign wrBase  = wrBuf ? BASE1 : BASE0;
  assign rdBase  = rdBuf ? BASE1 : BASE0;
  assign rdOther = rdBuf ? BASE0 : BASE1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      wrBuf   <= 1'b0;
      rdBuf   <= 1'b0;
      wrCmdTag <= '0;
      rdCmdTag <= '0;
      errFlag <= 1'b0;
    end else begin
      if (wrCtl.step) wrIdx <= wrIdx + 1'b1;
      else if (wrCtl.wrapSwap || wrCtl.wrapSame) wrIdx <= '0;
      if (wrCtl.wrapSwap) wrBuf <= ~wrBuf;
      if (rdCtl.step) rdIdx <= rdIdx + 1'b1;
      else if (rdCtl.wrapSwap || rdCtl.wrapSame) rdIdx <= '0;
      if (rdCtl.wrapSwap) rdBuf <= ~rdBuf;
      if (wrDone) wrCmdTag <= wrCmdTag + 1'b1;
      if (rdDone) rdCmdTag <= rdCmdTag + 1'b1;
      errFlag <= errFlag | (wrDone & wrStsErr) | (rdDone & rdStsErr);
    end
  end

  assign wrTagHit  = wrStsValid && (wrStsTag == wrCmdTag);
  assign rdTagHit  = rdStsValid && (rdStsTag == rdCmdTag);
  assign wrLast    = (wrIdx == IDX_W'(FRAME_XFERS - 1));
  assign rdLast    = (rdIdx == IDX_W'(RD_LAST));
  assign wrCmdAddr = wrBase + ADDR_W'(wrIdx) * STEP;
  assign wrCmdLen  = LEN_W'(XFER_BYTES);

  generate
    if (SKEW_BYTES > 0) begin : g_skew
      always_comb begin
        if (rdIdx == '0) begin
          rdCmdAddr = rdBase + ADDR_W'(SKEW_BYTES);
          rdCmdLen  = LEN_W'(XFER_BYTES - SKEW_BYTES);
        end else if (rdLast) begin
          rdCmdAddr = rdOther;
          rdCmdLen  = LEN_W'(SKEW_BYTES);
        end else begin
          rdCmdAddr = rdBase + ADDR_W'(rdIdx) * STEP;
          rdCmdLen  = LEN_W'(XFER_BYTES);
        end
      end
    end else begin : g_plain
      assign rdCmdAddr = rdBase + ADDR_W'(rdIdx) * STEP;
      assign rdCmdLen  = LEN_W'(XFER_BYTES);
    end
  endgenerate
endmodule

// File: rtl/fbdma_top.sv
module fbdma_top
  import fbdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 4,
  parameter int XFER_BYTES  = 64,
  parameter int STRIDE_MUL  = 2,
  parameter int SKEW_BYTES  = 32,
  parameter int FRAME_XFERS = 9600,
  parameter logic [ADDR_W-1:0] BASE0 = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] BASE1 = 32'h8020_0000,
  localparam int LEN_W = $clog2(XFER_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inHasBurst,
  input  logic              outHasRoom,
  output logic              wrCmdValid,
  input  logic              wrCmdReady,
  output logic [ADDR_W-1:0] wrCmdAddr,
  output logic [LEN_W-1:0]  wrCmdLen,
  output logic [TAG_W-1:0]  wrCmdTag,
  input  logic              wrStsValid,
  input  logic [TAG_W-1:0]  wrStsTag,
  input  logic              wrStsErr,
  output logic              rdCmdValid,
  input  logic              rdCmdReady,
  output logic [ADDR_W-1:0] rdCmdAddr,
  output logic [LEN_W-1:0]  rdCmdLen,
  output logic [TAG_W-1:0]  rdCmdTag,
  input  logic              rdStsValid,
  input  logic [TAG_W-1:0]  rdStsTag,
  input  logic              rdStsErr,
  output logic              errFlag
);
  stepCtl_t wrCtl, rdCtl;
  logic     wrTagHit, rdTagHit, wrLast, rdLast, wrBuf, rdBuf;

  fbdma_ctrl uCtrl (
    .clk, .rstN, .inHasBurst, .outHasRoom, .wrCmdReady, .rdCmdReady,
    .wrTagHit, .rdTagHit, .wrLast, .rdLast, .wrBuf, .rdBuf,
    .wrCmdValid, .rdCmdValid, .wrCtl, .rdCtl
  );

  fbdma_path #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .XFER_BYTES(XFER_BYTES),
    .STRIDE_MUL(STRIDE_MUL), .SKEW_BYTES(SKEW_BYTES),
    .FRAME_XFERS(FRAME_XFERS), .BASE0(BASE0), .BASE1(BASE1)
  ) uPath (
    .clk, .rstN, .wrCtl, .rdCtl,
    .wrStsValid, .wrStsTag, .wrStsErr, .rdStsValid, .rdStsTag, .rdStsErr,
    .wrCmdAddr, .wrCmdLen, .wrCmdTag, .rdCmdAddr, .rdCmdLen, .rdCmdTag,
    .wrTagHit, .rdTagHit, .wrLast, .rdLast, .wrBuf, .rdBuf, .errFlag
  );
endmodule

// File: rtl/fbdma_chk.sv
module fbdma_chk #(
  parameter int TAG_W      = 4,
  parameter int XFER_BYTES = 64,
  parameter int SKEW_BYTES = 32,
  parameter int LEN_W      = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             inHasBurst,
  input logic             outHasRoom,
  input logic             wrCmdValid,
  input logic             wrCmdReady,
  input logic [LEN_W-1:0] wrCmdLen,
  input logic [TAG_W-1:0] wrCmdTag,
  input logic             wrStsValid,
  input logic [TAG_W-1:0] wrStsTag,
  input logic             rdCmdValid,
  input logic             rdCmdReady,
  input logic [LEN_W-1:0] rdCmdLen,
  input logic [TAG_W-1:0] rdCmdTag,
  input logic             rdStsValid,
  input logic [TAG_W-1:0] rdStsTag,
  input logic             errFlag
);
  logic             wrBusy, rdBusy, wrSeen, rdSeen;
  logic [TAG_W-1:0] wrOut, rdOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBusy <= 1'b0; rdBusy <= 1'b0; wrSeen <= 1'b0; rdSeen <= 1'b0;
      wrOut  <= '0;   rdOut  <= '0;
    end else begin
      if (wrCmdValid && wrCmdReady) begin
        wrBusy <= 1'b1; wrOut <= wrCmdTag; wrSeen <= 1'b1;
      end else if (wrStsValid && wrStsTag == wrOut) wrBusy <= 1'b0;
      if (rdCmdValid && rdCmdReady) begin
        rdBusy <= 1'b1; rdOut <= rdCmdTag; rdSeen <= 1'b1;
      end else if (rdStsValid && rdStsTag == rdOut) rdBusy <= 1'b0;
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN) wrBusy |-> !wrCmdValid); // R4
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rstN) rdBusy |-> !rdCmdValid); // R4
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rstN)
    wrCmdValid |-> wrCmdLen == LEN_W'(XFER_BYTES)); // R1
  AST_RD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    rdCmdValid |-> (rdCmdLen == LEN_W'(XFER_BYTES) || rdCmdLen == LEN_W'(SKEW_BYTES)
                    || rdCmdLen == LEN_W'(XFER_BYTES - SKEW_BYTES))); // R8
  AST_WR_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrCmdValid) |-> $past(inHasBurst)); // R2
  AST_RD_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdCmdValid) |-> $past(outHasRoom)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9
  AST_WR_TAG_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmdValid && wrSeen && !wrBusy) |-> wrCmdTag == TAG_W'(wrOut + 1'b1)); // R11
  AST_RD_TAG_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmdValid && rdSeen && !rdBusy) |-> rdCmdTag == TAG_W'(rdOut + 1'b1)); // R11
endmodule

bind fbdma_top fbdma_chk #(
  .TAG_W(TAG_W), .XFER_BYTES(XFER_BYTES), .SKEW_BYTES(SKEW_BYTES), .LEN_W(LEN_W)
) uChk (.*);

// File: tb/sim_fbdma_top.sv
`timescale 1ns/100ps
module sim_fbdma_top;
  localparam int N = 3;
  localparam int STEP = 128;
  localparam logic [31:0] B0 = 32'h0000_1000;
  localparam logic [31:0] B1 = 32'h0000_8000;

  logic clk = 1'b0, rstN = 1'b0;
  logic inHasBurst = 1'b0, outHasRoom = 1'b0;
  logic wrCmdValid, rdCmdValid, errFlag;
  logic wrCmdReady = 1'b1, rdCmdReady = 1'b1;
  logic [31:0] wrCmdAddr, rdCmdAddr;
  logic [6:0]  wrCmdLen, rdCmdLen;
  logic [3:0]  wrCmdTag, rdCmdTag;
  logic wrStsValid = 1'b0, wrStsErr = 1'b0, rdStsValid = 1'b0, rdStsErr = 1'b0;
  logic [3:0] wrStsTag = '0, rdStsTag = '0;

  int testCount = 0, failCount = 0;
  int wrBudget = 0, rdBudget = 0, wrSts = 0, rdSts = 0, wrSeenCmds = 0, rdSeenCmds = 0;
  int wrTagExp = 0, rdTagExp = 0;
  bit wrBadTagNext = 0, wrErrNext = 0, finished = 0;

  typedef struct { logic [31:0] a; int l; int t; string req; } exp_t;
  exp_t wrQ[$], rdQ[$];

  always #2.5 clk = ~clk;

  fbdma_top #(.FRAME_XFERS(N), .STRIDE_MUL(2), .SKEW_BYTES(32), .TAG_W(4),
              .BASE0(B0), .BASE1(B1)) u0 (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] baseOf(int r);
    return r ? B1 : B0;
  endfunction

  task automatic pushWr(int r, int k, string req);
    wrQ.push_back('{baseOf(r) + k * STEP, 64, wrTagExp & 15, req});
    wrTagExp++;
  endtask

  task automatic pushRdRegion(int r, string req);
    rdQ.push_back('{baseOf(r) + 32, 32, rdTagExp & 15, req}); rdTagExp++;
    for (int k = 1; k < N; k++) begin
      rdQ.push_back('{baseOf(r) + k * STEP, 64, rdTagExp & 15, req}); rdTagExp++;
    end
    rdQ.push_back('{baseOf(1 - r), 32, rdTagExp & 15, req}); rdTagExp++;
  endtask

  // fill-side engine model and monitor
  initial begin : wrEngine
    exp_t e; logic [3:0] tg;
    forever begin
      @(negedge clk);
      if (rstN && wrCmdValid) begin
        wrSeenCmds++;
        tg = wrCmdTag;
        if (wrQ.size() == 0) check(0, "R2 unexpected fill command", wrCmdAddr, 0);
        else begin
          e = wrQ.pop_front();
          check(wrCmdAddr == e.a, {e.req, " fill addr"}, wrCmdAddr, e.a);
          check(wrCmdLen == 7'(e.l), "R1 fill len", 32'(wrCmdLen), e.l);
          check(wrCmdTag == 4'(e.t), "R11 fill tag", 32'(wrCmdTag), e.t);
        end
        wrBudget--;
        if (wrBudget == 0) inHasBurst = 1'b0;
        repeat ($urandom_range(1, 6)) @(negedge clk);
        if (wrBadTagNext) begin
          wrBadTagNext = 0;
          wrStsValid = 1'b1; wrStsTag = tg ^ 4'h5; wrStsErr = 1'b0;
          @(negedge clk); wrStsValid = 1'b0;
          for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!wrCmdValid, "R4 wrong-tag status ignored", 32'(wrCmdValid), 0);
          end
        end
        wrStsValid = 1'b1; wrStsTag = tg; wrStsErr = wrErrNext; wrErrNext = 0;
        @(negedge clk);
        wrStsValid = 1'b0; wrStsErr = 1'b0;
        wrSts++;
      end
    end
  end

  // drain-side engine model and monitor
  initial begin : rdEngine
    exp_t e; logic [3:0] tg;
    forever begin
      @(negedge clk);
      if (rstN && rdCmdValid) begin
        rdSeenCmds++;
        tg = rdCmdTag;
        if (rdQ.size() == 0) check(0, "R3 unexpected drain command", rdCmdAddr, 0);
        else begin
          e = rdQ.pop_front();
          check(rdCmdAddr == e.a, {e.req, " drain addr"}, rdCmdAddr, e.a);
          check(rdCmdLen == 7'(e.l), "R8 drain len", 32'(rdCmdLen), e.l);
          check(rdCmdTag == 4'(e.t), "R11 drain tag", 32'(rdCmdTag), e.t);
        end
        rdBudget--;
        if (rdBudget == 0) outHasRoom = 1'b0;
        repeat ($urandom_range(1, 6)) @(negedge clk);
        rdStsValid = 1'b1; rdStsTag = tg; rdStsErr = 1'b0;
        @(negedge clk);
        rdStsValid = 1'b0;
        rdSts++;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    check(!wrCmdValid && !rdCmdValid, "R10 valids low in reset", {wrCmdValid, rdCmdValid}, 0);
    check(!errFlag, "R10 errFlag low in reset", errFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!wrCmdValid && !rdCmdValid && !errFlag, "R10 idle after reset",
          {wrCmdValid, rdCmdValid, errFlag}, 0);

    // no frame yet, room present, no data: nothing may issue
    outHasRoom = 1'b1; rdBudget = 1000;
    repeat (40) @(negedge clk);
    check(rdSeenCmds == 0, "R7 drain idle before first frame", rdSeenCmds, 0);
    check(wrSeenCmds == 0, "R2 fill idle without data", wrSeenCmds, 0);
    outHasRoom = 1'b0;

    // fill region 0
    for (int k = 0; k < N; k++) pushWr(0, k, "R7 R1");
    wrBudget = N; inHasBurst = 1'b1;
    wait (wrSts == N); repeat (20) @(negedge clk);
    check(rdSeenCmds == 0, "R3 drain idle without room", rdSeenCmds, 0);
    check(!errFlag, "R9 errFlag low before errors", errFlag, 0);

    // drain: region 1 not full, so region 0 is read twice
    pushRdRegion(0, "R8"); pushRdRegion(0, "R6 reread");
    rdBudget = 2 * (N + 1); outHasRoom = 1'b1;
    wait (rdSts == 2 * (N + 1)); repeat (10) @(negedge clk);

    // fill region 1 right after region 0
    for (int k = 0; k < N; k++) pushWr(1, k, "R5");
    wrBudget = N; inHasBurst = 1'b1;
    wait (wrSts == 2 * N); repeat (5) @(negedge clk);

    // drain finishes region 0, then swaps to finished region 1
    pushRdRegion(0, "R6 pending region"); pushRdRegion(1, "R6 swap");
    rdBudget = 2 * (N + 1); outHasRoom = 1'b1;
    wait (rdSts == 4 * (N + 1)); repeat (5) @(negedge clk);

    // writer returns to region 0; wrong tag first, then error status
    pushWr(0, 0, "R5 wrap"); pushWr(0, 1, "R4");
    wrBadTagNext = 1; wrErrNext = 1;
    wrBudget = 2; inHasBurst = 1'b1;
    wait (wrSts == 2 * N + 2); repeat (5) @(negedge clk);
    check(errFlag, "R9 errFlag set by error status", errFlag, 1);

    // region 0 being rewritten: drain rereads region 1
    pushRdRegion(1, "R6 reread after rewrite");
    rdBudget = N + 1; outHasRoom = 1'b1;
    wait (rdSts == 5 * (N + 1)); repeat (10) @(negedge clk);
    check(errFlag, "R9 errFlag sticky", errFlag, 1);
    check(wrQ.size() == 0, "R4 all fill commands seen", wrQ.size(), 0);
    check(rdQ.size() == 0, "R6 all drain commands seen", rdQ.size(), 0);
    summary();
  end
endmodule